// File: doc/BRIEF.md
# CAN Controller Control and Interrupt Register

This block is the main control register of a CAN protocol controller, together with the interrupt logic and the write lock on the timing configuration. A CPU reaches it through a plain synchronous register port. Each access presents an address, write data, a write strobe and two byte enables. Read data comes back combinationally for the address currently presented. Address 0 holds the 16-bit control word. Addresses 1 to `NUM_PROT` hold a generic bank of protected configuration words. In a full controller these stand in for the bit-timing, prescaler-extension and operation-mode settings.

The protocol core sends single-cycle event pulses into the block:
- a bus-off status change and an error-warning status change, which feed a pending error interrupt;
- a completed transfer and a detected bus error, which feed a pending status interrupt.

Each event is latched only while its enable bit is set. The enabled pending flags are combined into one active-low interrupt pin, `irq_n`. A clear strobe stands for the CPU's read of the status register and drops both pending flags. The core also signals entry into bus-off, which forces the initialization bit high on its own.

The register port has no back-pressure: every access completes in the cycle it is presented. For that reason it carries no valid/ready pair, and all core-side pins are plain level or pulse signals.

Top module: `can_ctl_irq_reg`

## Requirements
- R1: The control word at address 0 maps its low byte as follows: bit 0 = INIT, bit 1 = IE (interrupt pin enable), bit 2 = SIE (status interrupt enable), bit 3 = EIE (error interrupt enable), bit 5 = DAR (no retransmission), bit 6 = CCE (configuration change enable), bit 7 = TEST. A write with byte enable 0 set updates these bits, and the next read returns them.
- R2: Bits 15..8 and bit 4 of the control word always read 0, whatever is written.
- R3: A write to a protected word at address 1..`NUM_PROT` takes effect only when CCE and INIT are both 1 before the write edge. `cfg_wr_ok` shows that condition. Byte enable 0 selects bits 7..0 and byte enable 1 selects bits 15..8.
- R4: When IE is 1 and a pending flag is set, `irq_n` is 0, and it stays 0 until the clear strobe removes every pending flag.
- R5: When IE is 0, `irq_n` is 1 whatever is pending.
- R6: When EIE is 1, a bus-off change or error-warning change pulse sets the pending error flag on that edge.
- R7: When SIE is 1, a transfer-complete or bus-error pulse sets the pending status flag on that edge.
- R8: A bus-off entry pulse sets INIT on that edge. If the CPU clears INIT in the same cycle, INIT is still set.
- R9: `stat_clr` clears both pending flags. A new enabled event in the same cycle keeps its flag set.
- R10: After reset the control word reads 0x0001, the protected words read 0 and `irq_n` is 1.
- R11: An event that arrives while its enable bit is 0 leaves no pending flag. Setting IE afterwards leaves `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_we | input | 1 | Write strobe |
| cpu_be | input | 2 | Byte enables |
| cpu_rdata | output | 16 | Read data for cpu_addr |
| evt_boff_chg | input | 1 | Bus-off status changed |
| evt_ewarn_chg | input | 1 | Error-warning status changed |
| evt_xfer_done | input | 1 | Transfer completed |
| evt_bus_err | input | 1 | Bus error detected |
| core_boff_entry | input | 1 | Core entered bus-off |
| stat_clr | input | 1 | Clear pending flags |
| init_o | output | 1 | INIT bit level |
| cfg_wr_ok | output | 1 | Protected writes permitted |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong pending flag or a wrong enable bit shows on `irq_n` in the cycle right after the edge that caused it. The one exception is when IE is 0. Then the fault stays hidden until IE is set, so the bench raises IE after masked events. A stray or missed INIT or CCE update appears at once on `init_o` and `cfg_wr_ok`. It then reaches the protected words through the next write, which read-back exposes. Corrupted control bits are visible on the very next read of address 0.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;
  localparam int DATA_W   = 16;
  localparam int BIT_INIT = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SIE  = 2;
  localparam int BIT_EIE  = 3;
  localparam int BIT_RSV  = 4;
  localparam int BIT_DAR  = 5;
  localparam int BIT_CCE  = 6;
  localparam int BIT_TEST = 7;
  localparam logic [7:0] CTRL_WMASK = 8'hEF;
  localparam logic [7:0] CTRL_RST   = 8'h01;

  typedef struct packed {
    logic test;
    logic cce;
    logic dar;
    logic rsv;
    logic eie;
    logic sie;
    logic ie;
    logic init;
  } ctrl_t;
endpackage

// File: rtl/can_ctl_ctrl_reg.sv
module can_ctl_ctrl_reg
  import can_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       boff_set,
  output ctrl_t      ctrl_q
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_t'(wr_byte & CTRL_WMASK);
    // core set of INIT overrides a CPU clear in the same cycle (R8)
    if (boff_set) ctrl_d.init = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= ctrl_t'(CTRL_RST);
    else        ctrl_q <= ctrl_d;
  end

  a_r8_core_sets_init: assert property (@(posedge clk) disable iff (!rst_n)
    boff_set |=> ctrl_q.init);
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !boff_set) |=> (ctrl_q.init == $past(wr_byte[BIT_INIT]) &&
                             ctrl_q.cce == $past(wr_byte[BIT_CCE])));
endmodule

// File: rtl/can_ctl_irq.sv
module can_ctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ie,
  input  logic sie,
  input  logic eie,
  input  logic boff_chg,
  input  logic ewarn_chg,
  input  logic xfer_done,
  input  logic bus_err,
  input  logic clr,
  output logic irq_n
);
  logic err_pend, st_pend;
  logic err_hit, st_hit;

  assign err_hit = eie && (boff_chg || ewarn_chg);
  assign st_hit  = sie && (xfer_done || bus_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pend <= 1'b0;
      st_pend  <= 1'b0;
    end else begin
      err_pend <= err_hit || (err_pend && !clr);
      st_pend  <= st_hit  || (st_pend  && !clr);
    end
  end

  assign irq_n = !(ie && (err_pend || st_pend));

  a_r6_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> err_pend);
  a_r7_st_raise: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit |=> st_pend);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err_hit && !st_hit) |=> (!err_pend && !st_pend));
  a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_pend && !st_pend && !err_hit && !st_hit) |=> irq_n);
  a_r4_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !clr) |=> (irq_n == !ie));
endmodule

// File: rtl/can_ctl_prot_bank.sv
module can_ctl_prot_bank #(
  parameter int NUM_PROT = 3,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        be,
  output logic [DATA_W-1:0] rdata,
  output logic              hit
);
  localparam int HALF = DATA_W / 2;
  logic [NUM_PROT-1:0][DATA_W-1:0] regs_q;

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_word
    logic sel;
    assign sel = (int'(addr) == i + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[i] <= '0;
      else if (wr_en && allow && sel) begin
        if (be[0]) regs_q[i][HALF-1:0]      <= wdata[HALF-1:0];
        if (be[1]) regs_q[i][DATA_W-1:HALF] <= wdata[DATA_W-1:HALF];
      end
    end
  end

  always_comb begin
    rdata = '0;
    hit   = 1'b0;
    for (int i = 0; i < NUM_PROT; i++) begin
      if (int'(addr) == i + 1) begin
        rdata = regs_q[i];
        hit   = 1'b1;
      end
    end
  end

  a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> $stable(regs_q));
endmodule

// File: rtl/can_ctl_irq_reg.sv
module can_ctl_irq_reg
  import can_ctl_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int NUM_PROT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_be,
  output logic [15:0]       cpu_rdata,
  input  logic              evt_boff_chg,
  input  logic              evt_ewarn_chg,
  input  logic              evt_xfer_done,
  input  logic              evt_bus_err,
  input  logic              core_boff_entry,
  input  logic              stat_clr,
  output logic              init_o,
  output logic              cfg_wr_ok,
  output logic              irq_n
);
  ctrl_t             ctrl_q;
  logic              ctrl_wr;
  logic [15:0]       bank_rd;
  logic              bank_hit;

  assign ctrl_wr = cpu_we && (cpu_addr == '0) && cpu_be[0];

  can_ctl_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wr_byte  (cpu_wdata[7:0]),
    .boff_set (core_boff_entry),
    .ctrl_q   (ctrl_q)
  );

  assign init_o    = ctrl_q.init;
  assign cfg_wr_ok = ctrl_q.cce && ctrl_q.init;

  can_ctl_prot_bank #(.NUM_PROT(NUM_PROT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .allow (cfg_wr_ok),
    .wr_en (cpu_we),
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .be    (cpu_be),
    .rdata (bank_rd),
    .hit   (bank_hit)
  );

  can_ctl_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ie        (ctrl_q.ie),
    .sie       (ctrl_q.sie),
    .eie       (ctrl_q.eie),
    .boff_chg  (evt_boff_chg),
    .ewarn_chg (evt_ewarn_chg),
    .xfer_done (evt_xfer_done),
    .bus_err   (evt_bus_err),
    .clr       (stat_clr),
    .irq_n     (irq_n)
  );

  always_comb begin
    if (cpu_addr == '0) cpu_rdata = {8'h00, ctrl_q};
    else if (bank_hit)  cpu_rdata = bank_rd;
    else                cpu_rdata = '0;
  end

  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == '0) |-> (cpu_rdata[15:8] == 8'h00 && !cpu_rdata[BIT_RSV]));
  a_r5_masked_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.ie && !(ctrl_wr && cpu_wdata[BIT_IE])) |=> irq_n);
endmodule

// File: tb/can_ctl_irq_reg_test.sv
module can_ctl_irq_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_be = '0;
  logic [15:0] cpu_rdata;
  logic        evt_boff_chg = 0, evt_ewarn_chg = 0, evt_xfer_done = 0, evt_bus_err = 0;
  logic        core_boff_entry = 0, stat_clr = 0;
  logic        init_o, cfg_wr_ok, irq_n;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0]  m_ctrl;
  logic        m_err, m_st;
  logic [15:0] m_prot [1:3];

  always #10 clk = ~clk;

  can_ctl_irq_reg #(.ADDR_W(2), .NUM_PROT(3)) uut (.*);

  function automatic logic exp_irq_n();
    return !(m_ctrl[1] && (m_err || m_st));
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    if (a == 0) return {8'h00, m_ctrl};
    return m_prot[a];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply the current inputs for one edge and advance the model
  task automatic step();
    logic [7:0] nc;
    nc = m_ctrl;
    if (cpu_we && cpu_addr == 0 && cpu_be[0]) nc = cpu_wdata[7:0] & 8'hEF;
    if (core_boff_entry) nc[0] = 1'b1;
    if (cpu_we && cpu_addr != 0 && m_ctrl[6] && m_ctrl[0]) begin
      if (cpu_be[0]) m_prot[cpu_addr][7:0]  = cpu_wdata[7:0];
      if (cpu_be[1]) m_prot[cpu_addr][15:8] = cpu_wdata[15:8];
    end
    m_err = (m_ctrl[3] && (evt_boff_chg || evt_ewarn_chg)) || (m_err && !stat_clr);
    m_st  = (m_ctrl[2] && (evt_xfer_done || evt_bus_err)) || (m_st && !stat_clr);
    m_ctrl = nc;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 0; evt_boff_chg = 0; evt_ewarn_chg = 0; evt_xfer_done = 0;
    evt_bus_err = 0; core_boff_entry = 0; stat_clr = 0;
  endtask

  task automatic check_pins();
    chk("R8 init_o", {15'd0, init_o}, {15'd0, m_ctrl[0]});
    chk("R3 cfg_wr_ok", {15'd0, cfg_wr_ok}, {15'd0, m_ctrl[6] & m_ctrl[0]});
    chk(m_ctrl[1] ? "R4 irq_n" : "R5 irq_n", {15'd0, irq_n}, {15'd0, exp_irq_n()});
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    cpu_addr = a;
    #1;
    chk(req, cpu_rdata, exp_read(a));
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_we = 1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m_ctrl = 8'h01; m_err = 0; m_st = 0;
    for (int i = 1; i <= 3; i++) m_prot[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    rd("R10 ctrl reset", 0);
    chk("R10 irq_n", {15'd0, irq_n}, 16'd1);
    for (int i = 1; i <= 3; i++) rd("R10 prot reset", 2'(i));

    // R1 / R2 layout and reserved bits
    wr(0, 16'hFFFF, 2'b11);
    rd("R2 reserved zero", 0);
    chk("R1 ctrl ff", cpu_rdata, 16'h00EF);
    wr(0, 16'h0041, 2'b01);
    rd("R1 ctrl cce+init", 0);

    // R3 protected writes, byte enables
    wr(1, 16'hA55A, 2'b10);
    rd("R3 upper byte only", 1);
    chk("R3 upper byte value", cpu_rdata, 16'hA500);
    wr(0, 16'h0040, 2'b01);                 // INIT=0, CCE=1
    wr(2, 16'h1234, 2'b11);
    rd("R3 locked when init low", 2);
    chk("R3 locked value", cpu_rdata, 16'h0000);

    // R8 core wins over CPU clear
    core_boff_entry = 1;
    wr(0, 16'h0040, 2'b01);
    check_pins();
    rd("R8 init set by core", 0);

    // R11 masked events, then raise IE
    wr(0, 16'h0000, 2'b01);
    evt_bus_err = 1; evt_ewarn_chg = 1; step();
    wr(0, 16'h0002, 2'b01);
    chk("R11 no pending after masked events", {15'd0, irq_n}, 16'd1);

    // R6 / R4 / R9
    wr(0, 16'h000A, 2'b01);
    evt_boff_chg = 1; step();
    chk("R6 err pend drives irq", {15'd0, irq_n}, 16'd0);
    step();
    chk("R4 irq held", {15'd0, irq_n}, 16'd0);
    wr(0, 16'h0008, 2'b01);
    chk("R5 IE low masks", {15'd0, irq_n}, 16'd1);
    wr(0, 16'h000E, 2'b01);
    chk("R4 pending survives mask", {15'd0, irq_n}, 16'd0);
    stat_clr = 1; evt_xfer_done = 1; step();
    chk("R9 set wins over clear", {15'd0, irq_n}, 16'd0);
    stat_clr = 1; step();
    chk("R9 cleared", {15'd0, irq_n}, 16'd1);
    // R7
    evt_bus_err = 1; step();
    chk("R7 status pend", {15'd0, irq_n}, 16'd0);
    stat_clr = 1; step();

    // constrained random
    for (int n = 0; n < 2000; n++) begin
      cpu_addr  = 2'($urandom_range(0, 3));
      cpu_wdata = 16'($urandom());
      if (cpu_addr == 0 && $urandom_range(0, 3) != 0) cpu_wdata[0] = 1'b1;
      cpu_be    = 2'($urandom_range(0, 3));
      cpu_we    = ($urandom_range(0, 3) == 0);
      evt_boff_chg    = ($urandom_range(0, 7) == 0);
      evt_ewarn_chg   = ($urandom_range(0, 7) == 0);
      evt_xfer_done   = ($urandom_range(0, 7) == 0);
      evt_bus_err     = ($urandom_range(0, 7) == 0);
      core_boff_entry = ($urandom_range(0, 15) == 0);
      stat_clr        = ($urandom_range(0, 3) == 0);
      step();
      check_pins();
      if (n % 8 == 0) rd("R1 R3 random readback", 2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule